// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers sixteen interrupt request lines and steers each one to one of eight CPU interrupt outputs. Every source has a small routing field in one of two route words. The field holds a target output number and an enable flag. Software reaches the block through a plain 32-bit word-addressed register port with a write strobe and a combinational read path.

Each raw input first passes through a two-flop synchronizer. Sources 0 to 4 are bus-style interrupt lines. Each of them can be made active-low and can be set to level or edge detection. Sources 5 to 15 are always active-high and level-sensitive.

Edge-detected events are latched until software writes a one to the matching bit of a clear register. For each output, the block shows which enabled, routed sources are pending. Each output is a registered OR of that status, gated by a per-output enable bit.

Word address map (default parameters, `reg_addr` is a word index):

| Addr | Content |
|------|---------|
| 0 | Route fields of sources 0 to 7; source i uses bits 4i+3..4i |
| 1 | Route fields of sources 8 to 15; source i uses bits 4(i-8)+3..4(i-8) |
| 2 to 5 | Status words; word 2+n/2 carries output n in bits 15:0 for even n and bits 31:16 for odd n |
| 6 | Output enables; output n at bit 16+n, the other bits read zero |
| 7 | Line modes; line k (0 to 4) uses bits 2k+1..2k, bits above 9 read zero |
| 8 | Clear register; write-one-to-clear, reads zero |

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every register word reads zero, every status bit is zero and `cpu_irq` is all zero.
- R2: For source i, the route field is at word i/8, bits 4*(i%8)+3..4*(i%8). Field bits [2:0] give the target output and bit 3 enables the source. The status halfword of output n shows bit i set exactly when source i is pending, enabled and routed to n. Route words read back as written.
- R3: A source whose enable bit is clear sets no status bit of any output and drives no `cpu_irq` output. Writing zero to both route words silences every source.
- R4: Writing the clear register (address 8) with bit n set discards the latched edge event of source n. Bits written as zero leave their sources unchanged. The clear register reads zero.
- R5: `cpu_irq[n]` is high exactly when the status halfword of output n was nonzero and enable bit 16+n of word 6 was set, one clock earlier. Bits 15:0 and 31:24 of word 6 read zero.
- R6: For line k (0 to 4), mode bit 2k set makes the line active-low and clear makes it active-high. Bit 2k+1 set selects level detection and clear selects edge detection.
- R7: In edge mode, a line becomes pending on its transition into the active level and stays pending after the line returns inactive, until it is cleared.
- R8: In level mode, pending follows the polarity-corrected line. A clear has no lasting effect while the line stays active, and pending drops once the line goes inactive.
- R9: Sources 5 to 15 are active-high and level-sensitive, whatever the mode word holds.
- R10: If a clear of source n lands in the same clock as a new edge event of source n, the source stays pending.
- R11: A raw input change shows up in the status words on the third rising clock edge after it is applied, and on `cpu_irq` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq | input | 16 | Raw interrupt request lines, asynchronous |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_irq | output | 8 | Routed and gated CPU interrupt outputs |

## Verification
The assertions check several rules on every cycle:
- an edge-mode pending bit holds unless cleared;
- a level-mode pending bit tracks the corrected line of the previous cycle;
- a clear never beats a simultaneous new edge;
- each source shows in at most one status halfword;
- a raised output always had its enable set and a nonzero status one cycle before.

Only the bench scenarios can show three other things. These are the exact field positions and polarity encodings seen from the register port, the latency count from a raw input change, and that partial clears and disabled routes leave the other sources alone.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned HALF_W  = 16;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_PCI = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  input  logic [NUM_OUT*NUM_SRC-1:0] status,
  output logic [NUM_SRC*SEL_W-1:0]   route_sel,
  output logic [NUM_SRC-1:0]         src_en,
  output logic [NUM_OUT-1:0]         out_en,
  output logic [NUM_PCI-1:0]         line_low,
  output logic [NUM_PCI-1:0]         line_level,
  output logic [NUM_SRC-1:0]         clr_pulse
);
  localparam int unsigned ROUTE_BITS  = NUM_SRC * FIELD_W;
  localparam int unsigned ROUTE_WORDS = (ROUTE_BITS + WORD_W - 1) / WORD_W;
  localparam int unsigned STAT_BASE   = ROUTE_WORDS;
  localparam int unsigned STAT_WORDS  = (NUM_OUT + 1) / 2;
  localparam int unsigned OEN_ADDR    = STAT_BASE + STAT_WORDS;
  localparam int unsigned MODE_ADDR   = OEN_ADDR + 1;
  localparam int unsigned CLR_ADDR    = MODE_ADDR + 1;
  localparam int unsigned MODE_W      = 2 * NUM_PCI;

  logic [ROUTE_WORDS*WORD_W-1:0] route_q, route_d;
  logic [NUM_OUT-1:0]            oen_q, oen_d;
  logic [MODE_W-1:0]             mode_q, mode_d;
  logic                          wr_route, wr_oen, wr_mode, wr_clr;

  always_comb begin
    wr_route = 1'b0;
    for (int w = 0; w < ROUTE_WORDS; w++) begin
      if (reg_addr == ADDR_W'(w)) wr_route = reg_wr;
    end
    wr_oen  = reg_wr && (reg_addr == ADDR_W'(OEN_ADDR));
    wr_mode = reg_wr && (reg_addr == ADDR_W'(MODE_ADDR));
    wr_clr  = reg_wr && (reg_addr == ADDR_W'(CLR_ADDR));
  end

  always_comb begin
    route_d = route_q;
    for (int w = 0; w < ROUTE_WORDS; w++) begin
      if (reg_wr && reg_addr == ADDR_W'(w)) route_d[w*WORD_W +: WORD_W] = reg_wdata;
    end
    oen_d  = wr_oen  ? reg_wdata[16 +: NUM_OUT] : oen_q;
    mode_d = wr_mode ? reg_wdata[MODE_W-1:0]    : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      oen_q   <= '0;
      mode_q  <= '0;
    end else begin
      if (wr_route) route_q <= route_d;
      if (wr_oen)   oen_q   <= oen_d;
      if (wr_mode)  mode_q  <= mode_d;
    end
  end

  assign clr_pulse = wr_clr ? reg_wdata[NUM_SRC-1:0] : '0;
  assign out_en    = oen_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    assign route_sel[i*SEL_W +: SEL_W] = route_q[i*FIELD_W +: SEL_W];
    assign src_en[i]                   = route_q[i*FIELD_W + SEL_W];
  end

  for (genvar k = 0; k < NUM_PCI; k++) begin : g_mode
    assign line_low[k]   = mode_q[2*k];
    assign line_level[k] = mode_q[2*k+1];
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < ROUTE_WORDS; w++) begin
      if (reg_addr == ADDR_W'(w)) reg_rdata = route_q[w*WORD_W +: WORD_W];
    end
    for (int n = 0; n < NUM_OUT; n++) begin
      if (reg_addr == ADDR_W'(STAT_BASE + n/2))
        reg_rdata[(n%2)*HALF_W +: NUM_SRC] = status[n*NUM_SRC +: NUM_SRC];
    end
    if (reg_addr == ADDR_W'(OEN_ADDR))  reg_rdata[16 +: NUM_OUT] = oen_q;
    if (reg_addr == ADDR_W'(MODE_ADDR)) reg_rdata[MODE_W-1:0]    = mode_q;
  end

  AST_OEN_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    !wr_oen |=> $stable(oen_q)); // R5
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_route |=> $stable(route_q)); // R2
  AST_MODE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q)); // R6
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_PCI = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_raw,
  input  logic [NUM_PCI-1:0] line_low,
  input  logic [NUM_PCI-1:0] line_level,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q, pend_q;
  logic [NUM_SRC-1:0] act, lvl, rise, pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_PCI) begin : g_line
      assign act[i] = sync_q[i] ^ line_low[i];
      assign lvl[i] = line_level[i];

      AST_EDGE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[i] && pend_q[i] && !clr[i]) |=> pend_q[i]); // R7
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[i] |=> (pend_q[i] == $past(act[i]))); // R8
      AST_EDGE_WINS:  assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[i] && act[i] && !prev_q[i] && clr[i]) |=> pend_q[i]); // R10
    end else begin : g_plain
      assign act[i] = sync_q[i];
      assign lvl[i] = 1'b1;

      AST_PLAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sync_q[i]) |=> (pend_q[i] == $past(sync_q[i]))); // R9
    end
  end

  always_comb begin
    rise   = act & ~prev_q;
    pend_d = (lvl & act) | (~lvl & (rise | (pend_q & ~clr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      meta_q <= src_raw;
      sync_q <= meta_q;
      prev_q <= act;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_OUT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*SEL_W-1:0]   route_sel,
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_OUT-1:0]         out_en,
  output logic [NUM_OUT*NUM_SRC-1:0] status,
  output logic [NUM_OUT-1:0]         cpu_irq
);
  logic [NUM_OUT-1:0] irq_d, irq_q;
  logic [NUM_OUT-1:0] any_pend;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      assign status[n*NUM_SRC + i] =
        pend[i] && src_en[i] && (route_sel[i*SEL_W +: SEL_W] == SEL_W'(n));
    end
    assign any_pend[n] = |status[n*NUM_SRC +: NUM_SRC];

    AST_OUT_GATED:  assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[n] |-> $past(out_en[n])); // R5
    AST_OUT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[n] |-> $past(any_pend[n])); // R5
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_col
    logic [NUM_OUT-1:0] col;
    for (genvar n = 0; n < NUM_OUT; n++) begin : g_bit
      assign col[n] = status[n*NUM_SRC + i];
    end
    AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R2
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[i] |-> (col == '0)); // R3
  end

  always_comb begin
    irq_d = any_pend & out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign cpu_irq = irq_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_PCI = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic [NUM_OUT-1:0] cpu_irq
);
  logic                       rst_meta_q, rst_sync_q;
  logic [NUM_OUT*NUM_SRC-1:0] status;
  logic [NUM_SRC*SEL_W-1:0]   route_sel;
  logic [NUM_SRC-1:0]         src_en, clr_pulse, pend;
  logic [NUM_OUT-1:0]         out_en;
  logic [NUM_PCI-1:0]         line_low, line_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  irq_route_regs #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_PCI(NUM_PCI), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status(status), .route_sel(route_sel), .src_en(src_en), .out_en(out_en),
    .line_low(line_low), .line_level(line_level), .clr_pulse(clr_pulse)
  );

  irq_src_cond #(.NUM_SRC(NUM_SRC), .NUM_PCI(NUM_PCI)) u_cond (
    .clk(clk), .rst_n(rst_sync_q), .src_raw(src_irq),
    .line_low(line_low), .line_level(line_level), .clr(clr_pulse), .pend(pend)
  );

  irq_route_matrix #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_matrix (
    .clk(clk), .rst_n(rst_sync_q), .pend(pend), .route_sel(route_sel),
    .src_en(src_en), .out_en(out_en), .status(status), .cpu_irq(cpu_irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |=> (cpu_irq == '0)); // R1
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_irq;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  cpu_irq;

  always #4 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 1'b0;
  logic [63:0] m_route;
  logic [7:0]  m_oen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_half(input int n, input logic [15:0] p);
    logic [15:0] h = '0;
    for (int i = 0; i < 16; i++)
      if (p[i] && m_route[4*i+3] && (m_route[4*i +: 3] == 3'(n))) h[i] = 1'b1;
    return h;
  endfunction

  function automatic logic [7:0] exp_irq(input logic [15:0] p);
    logic [7:0] o = '0;
    for (int n = 0; n < 8; n++) o[n] = (|exp_half(n, p)) && m_oen[n];
    return o;
  endfunction

  task automatic chk_all(input string req, input logic [15:0] p);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(4'(2 + w), d);
      check(req, d, {exp_half(2*w+1, p), exp_half(2*w, p)});
    end
    check(req, {24'b0, cpu_irq}, {24'b0, exp_irq(p)});
  endtask

  task automatic set_route(input logic [63:0] r);
    m_route = r;
    wr(4'd0, r[31:0]);
    wr(4'd1, r[63:32]);
  endtask

  task automatic set_oen(input logic [7:0] v);
    m_oen = v;
    wr(4'd6, {8'b0, v, 16'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [4:0]  lowmask;
    logic [31:0] mode;
    int unsigned seed;
    rst_n = 1'b0; src_irq = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_route = '0; m_oen = '0;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d);
      check("R1", d, 32'h0);
    end
    check("R1", {24'b0, cpu_irq}, 32'h0);

    // R2 / R5 / R6 / R4: readback and field widths
    wr(4'd0, 32'hA5A5_1234); rd(4'd0, d); check("R2", d, 32'hA5A5_1234);
    wr(4'd1, 32'h0F0F_9876); rd(4'd1, d); check("R2", d, 32'h0F0F_9876);
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, d); check("R5", d, 32'h00FF_0000);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); check("R6", d, 32'h0000_03FF);
    wr(4'd8, 32'h0000_0000); rd(4'd8, d); check("R4", d, 32'h0);
    set_route('0); set_oen('0); wr(4'd7, 32'h0);

    // Random: all bus lines in level mode with random polarity
    lowmask = 5'($urandom);
    mode = '0;
    for (int k = 0; k < 5; k++) begin
      mode[2*k]   = lowmask[k];
      mode[2*k+1] = 1'b1;
    end
    wr(4'd7, mode);
    for (int it = 0; it < 40; it++) begin
      set_route({$urandom, $urandom});
      set_oen(8'($urandom));
      @(negedge clk) src_irq = 16'($urandom);
      idle(6);
      chk_all("R2", src_irq ^ {11'b0, lowmask});
    end

    // Directed setup: all bus lines edge, active-high
    @(negedge clk) src_irq = '0;
    idle(6);
    wr(4'd7, 32'h0);
    wr(4'd8, 32'h0000_FFFF);
    set_route({32'h0000_00C0, 32'h01BF_D08A});
    set_oen(8'hFF);
    idle(2);
    chk_all("R4", 16'h0000);

    // R7: edge latch holds after line drops
    @(negedge clk) src_irq[0] = 1'b1;
    idle(3);
    src_irq[0] = 1'b0;
    idle(6);
    chk_all("R7", 16'h0001);

    // R4: zero bits leave source alone, one bit clears
    wr(4'd8, 32'h0000_FFFE); idle(2); chk_all("R4", 16'h0001);
    wr(4'd8, 32'h0000_0001); idle(2); chk_all("R4", 16'h0000);

    // R10: clear in the same cycle as a new edge
    @(negedge clk) src_irq[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h0000_0008;
    @(negedge clk) reg_wr = 1'b0;
    idle(2);
    chk_all("R10", 16'h0008);
    wr(4'd8, 32'h0000_0008); idle(2); chk_all("R4", 16'h0000);
    @(negedge clk) src_irq[3] = 1'b0;
    idle(6);

    // R6: active-low edge on line 4
    @(negedge clk) src_irq[4] = 1'b1;
    idle(4);
    wr(4'd7, 32'h0000_0100);
    idle(2);
    wr(4'd8, 32'h0000_FFFF);
    idle(2);
    chk_all("R6", 16'h0000);
    @(negedge clk) src_irq[4] = 1'b0;
    idle(3);
    src_irq[4] = 1'b1;
    idle(6);
    chk_all("R6", 16'h0010);

    // R8: level, active-low on line 1
    @(negedge clk) src_irq[1] = 1'b1;
    wr(4'd7, 32'h0000_010C);
    idle(6);
    wr(4'd8, 32'h0000_FFFF);
    idle(2);
    chk_all("R8", 16'h0000);
    @(negedge clk) src_irq[1] = 1'b0;
    idle(6);
    chk_all("R8", 16'h0002);
    wr(4'd8, 32'h0000_0002); idle(3); chk_all("R8", 16'h0002);
    @(negedge clk) src_irq[1] = 1'b1;
    idle(6);
    chk_all("R8", 16'h0000);

    // R11: latency, source 5 routed to output 3 (word 3, bit 21)
    @(negedge clk);
    reg_addr = 4'd3;
    src_irq[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 check("R11", {31'b0, reg_rdata[21]}, 32'h0);
    @(posedge clk);
    #1 check("R11", {31'b0, reg_rdata[21]}, 32'h1);
    check("R11", {31'b0, cpu_irq[3]}, 32'h0);
    @(posedge clk);
    #1 check("R11", {31'b0, cpu_irq[3]}, 32'h1);

    // R5: output gated off while status is set
    set_oen(8'hF7);
    idle(2);
    chk_all("R5", 16'h0020);
    set_oen(8'hFF);
    @(negedge clk) src_irq[5] = 1'b0;
    idle(6);

    // R3: disabled source, then enabled, then all route words zero
    @(negedge clk) src_irq[6] = 1'b1;
    idle(6);
    chk_all("R3", 16'h0040);
    set_route({m_route[63:28], 4'b1001, m_route[23:0]});
    idle(2);
    chk_all("R3", 16'h0040);
    set_route('0);
    idle(2);
    chk_all("R3", 16'h0040);
    set_route({32'h0000_00C0, 32'h01BF_D08A});
    @(negedge clk) src_irq[6] = 1'b0;
    idle(6);

    // R9: plain source is level, clear has no lasting effect
    @(negedge clk) src_irq[9] = 1'b1;
    idle(6);
    chk_all("R9", 16'h0200);
    wr(4'd8, 32'h0000_0200); idle(3); chk_all("R9", 16'h0200);
    @(negedge clk) src_irq[9] = 1'b0;
    idle(6);
    chk_all("R9", 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule